// File: doc/BRIEF.md
# Standby Output Retention Unit

This unit keeps the levels of a bank of general-purpose outputs while the core logic is powered down. Software arms retention by setting an enable bit. When the standby-entry strobe arrives with the bit set, the unit captures the live level of every output. For each retained pin it then drives a weak pull, up for a one and down for a zero, and it holds the normal output driver off. If retention is not armed, standby only turns the drivers off, so the pins float.

The captured pulls stay in place through wakeup. They are released only when software clears the enable bit, and that also returns the pins to their normal drivers. Some pins are never retained. A parameter mask names the ones that are always excluded, such as debug-probe pins and pins that have a standby function. A run-time mask input can exclude more. An excluded pin never shows a pull or a driver override.

All outputs are registered. Each one takes the value implied by the inputs at the same rising edge that samples those inputs.

Top module: `standby_io_retain`

## Requirements
- R1: Synchronous reset, active high, clears the enable bit and the standby and held states, and drives every pull_up, pull_dn and drv_off bit to 0.
- R2: A pulse on ret_en_set sets ret_en at the next edge. A pulse on ret_en_clr clears it. If both arrive in the same cycle, the clear wins.
- R3: A standby entry with retention not armed sets drv_off for every pin that is not excluded, and applies no pull.
- R4: A standby entry with retention armed captures pin_out in that cycle. Each retained pin then shows pull_up=1 if it was 1, or pull_dn=1 if it was 0, with drv_off=1. Later changes on pin_out have no effect.
- R5: After a retention capture, a wakeup leaves every pull and drv_off bit unchanged.
- R6: A ret_en_clr pulse clears ret_en, all pulls and all drv_off bits at the edge that samples it, provided the unit is not in standby.
- R7: Pins set in parameter FIXED_EXCL (default 8'h81, that is bits 0 and 7) never assert pull_up, pull_dn or drv_off.
- R8: A pin whose excl_mask bit is 1 shows 0 on all three outputs from the edge that samples the mask. Clearing the mask bit again restores that pin's captured pull.
- R9: A second standby entry while a capture is still held, with ret_en still set, captures pin_out again and replaces the held levels.
- R10: A standby entry in the same cycle as ret_en_clr captures nothing. The pins then only have their drivers disabled.
- R11: Without a held capture, a wakeup returns drv_off to 0 at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_out | input | PINS | Live output levels of the bank |
| excl_mask | input | PINS | Run-time exclusion, 1 = never retain |
| ret_en_set | input | 1 | Software pulse that sets the enable bit |
| ret_en_clr | input | 1 | Software pulse that clears the enable bit |
| standby_enter | input | 1 | Pulse marking entry into standby |
| wakeup | input | 1 | Pulse marking exit from standby |
| ret_en | output | 1 | Current enable bit |
| pull_up | output | PINS | Per-pin pull-up enable |
| pull_dn | output | PINS | Per-pin pull-down enable |
| drv_off | output | PINS | Per-pin normal driver disable |

## Verification
The bench changes pin_out after a capture to catch a design that follows the live level instead of holding the captured one. It issues a wakeup with retention held, which a design that ties the pulls to the standby state would drop. It checks a second entry with different levels, which a design that captures only once would miss. It also drives an entry in the same cycle as a clear, where a design with the wrong priority would retain pins after software released them. Both the fixed and the run-time exclusion masks are exercised, so a design that lets an excluded pin pull or lose its driver is reported.

// File: rtl/sret_pkg.sv
package sret_pkg;
  typedef struct packed {
    logic en;
    logic stby;
    logic held;
  } sret_state_t;

  localparam sret_state_t SRET_IDLE = '{en: 1'b0, stby: 1'b0, held: 1'b0};
endpackage

// File: rtl/sret_ctrl.sv
module sret_ctrl
  import sret_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en_set,
  input  logic        en_clr,
  input  logic        stby_enter,
  input  logic        wake,
  output sret_state_t st_d,
  output logic        capture,
  output logic        en_q
);
  sret_state_t st_q;

  always_comb begin
    st_d    = st_q;
    capture = 1'b0;
    if (en_clr)      st_d.en = 1'b0;
    else if (en_set) st_d.en = 1'b1;

    if (stby_enter)  st_d.stby = 1'b1;
    else if (wake)   st_d.stby = 1'b0;

    capture = stby_enter && st_d.en;
    if (!st_d.en)    st_d.held = 1'b0;
    else if (capture) st_d.held = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SRET_IDLE;
    else     st_q <= st_d;
  end

  assign en_q = st_q.en;
endmodule

// File: rtl/sret_sample.sv
module sret_sample #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] level_d
);
  logic [PINS-1:0] level_q;

  assign level_d = capture ? pin_out : level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end
endmodule

// File: rtl/sret_drive.sv
module sret_drive #(
  parameter int              PINS       = 8,
  parameter logic [PINS-1:0] FIXED_EXCL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            held_d,
  input  logic            stby_d,
  input  logic [PINS-1:0] level_d,
  input  logic [PINS-1:0] excl_mask,
  output logic [PINS-1:0] pull_up,
  output logic [PINS-1:0] pull_dn,
  output logic [PINS-1:0] drv_off
);
  logic [PINS-1:0] keep;
  assign keep = ~(FIXED_EXCL | excl_mask);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pull_up[i] <= 1'b0;
        pull_dn[i] <= 1'b0;
        drv_off[i] <= 1'b0;
      end else begin
        pull_up[i] <= keep[i] && held_d && level_d[i];
        pull_dn[i] <= keep[i] && held_d && !level_d[i];
        drv_off[i] <= keep[i] && (held_d || stby_d);
      end
    end
  end
endmodule

// File: rtl/standby_io_retain.sv
module standby_io_retain #(
  parameter int              PINS       = 8,
  parameter logic [PINS-1:0] FIXED_EXCL = 8'h81
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_out,
  input  logic [PINS-1:0] excl_mask,
  input  logic            ret_en_set,
  input  logic            ret_en_clr,
  input  logic            standby_enter,
  input  logic            wakeup,
  output logic            ret_en,
  output logic [PINS-1:0] pull_up,
  output logic [PINS-1:0] pull_dn,
  output logic [PINS-1:0] drv_off
);
  import sret_pkg::*;

  sret_state_t     st_d;
  logic            capture;
  logic [PINS-1:0] level_d;

  sret_ctrl u_ctrl (
    .clk(clk), .rst(rst), .en_set(ret_en_set), .en_clr(ret_en_clr),
    .stby_enter(standby_enter), .wake(wakeup),
    .st_d(st_d), .capture(capture), .en_q(ret_en)
  );

  sret_sample #(.PINS(PINS)) u_sample (
    .clk(clk), .rst(rst), .capture(capture), .pin_out(pin_out),
    .level_d(level_d)
  );

  sret_drive #(.PINS(PINS), .FIXED_EXCL(FIXED_EXCL)) u_drive (
    .clk(clk), .rst(rst), .held_d(st_d.held), .stby_d(st_d.stby),
    .level_d(level_d), .excl_mask(excl_mask),
    .pull_up(pull_up), .pull_dn(pull_dn), .drv_off(drv_off)
  );
endmodule

// File: rtl/sret_checker.sv
module sret_checker #(
  parameter int              PINS       = 8,
  parameter logic [PINS-1:0] FIXED_EXCL = '0
) (
  input logic            clk,
  input logic            rst,
  input logic [PINS-1:0] excl_mask,
  input logic            ret_en_set,
  input logic            ret_en_clr,
  input logic            standby_enter,
  input logic            ret_en,
  input logic [PINS-1:0] pull_up,
  input logic [PINS-1:0] pull_dn,
  input logic [PINS-1:0] drv_off
);
  AST_PULL_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    (pull_up & pull_dn) == '0); // R4
  AST_PULL_DRV_OFF: assert property (@(posedge clk) disable iff (rst)
    ((pull_up | pull_dn) & ~drv_off) == '0); // R4
  AST_FIXED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((pull_up | pull_dn | drv_off) & FIXED_EXCL) == '0); // R7
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    ##1 ((pull_up | pull_dn | drv_off) & $past(excl_mask)) == '0); // R8
  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ret_en_clr |=> (!ret_en && pull_up == '0 && pull_dn == '0)); // R6
  AST_NO_ARM_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    (standby_enter && !ret_en && !ret_en_set) |=> (pull_up | pull_dn) == '0); // R3
  AST_PULL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (pull_up | pull_dn) != '0 |-> ret_en); // R5
endmodule

bind standby_io_retain sret_checker #(.PINS(PINS), .FIXED_EXCL(FIXED_EXCL)) u_chk (
  .clk(clk), .rst(rst), .excl_mask(excl_mask), .ret_en_set(ret_en_set),
  .ret_en_clr(ret_en_clr), .standby_enter(standby_enter), .ret_en(ret_en),
  .pull_up(pull_up), .pull_dn(pull_dn), .drv_off(drv_off)
);

// File: tb/test_standby_io_retain.sv
module test_standby_io_retain;
  localparam int         PINS  = 8;
  localparam logic [7:0] FIXED = 8'h81;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pin_out = '0, excl_mask = '0;
  logic ret_en_set = 0, ret_en_clr = 0, standby_enter = 0, wakeup = 0;
  logic ret_en;
  logic [7:0] pull_up, pull_dn, drv_off;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  standby_io_retain #(.PINS(PINS), .FIXED_EXCL(FIXED)) i_standby_io_retain (
    .clk(clk), .rst(rst), .pin_out(pin_out), .excl_mask(excl_mask),
    .ret_en_set(ret_en_set), .ret_en_clr(ret_en_clr),
    .standby_enter(standby_enter), .wakeup(wakeup), .ret_en(ret_en),
    .pull_up(pull_up), .pull_dn(pull_dn), .drv_off(drv_off)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic [7:0] up, logic [7:0] dn, logic [7:0] off);
    chk(req, "pull_up", pull_up, up);
    chk(req, "pull_dn", pull_dn, dn);
    chk(req, "drv_off", drv_off, off);
  endtask

  // Apply strobes for one cycle. Inputs change on the falling edge,
  // results are read on the next falling edge.
  task automatic step(bit s, bit c, bit e, bit w);
    ret_en_set = s; ret_en_clr = c; standby_enter = e; wakeup = w;
    @(negedge clk);
    ret_en_set = 0; ret_en_clr = 0; standby_enter = 0; wakeup = 0;
  endtask

  task automatic t_reset();
    chk("R1", "ret_en", {7'd0, ret_en}, 8'h00);
    chk_all("R1", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_enable();
    step(1, 0, 0, 0); chk("R2", "ret_en set", {7'd0, ret_en}, 8'h01);
    step(1, 1, 0, 0); chk("R2", "clr wins", {7'd0, ret_en}, 8'h00);
  endtask

  task automatic t_no_retain();
    pin_out = 8'h5A;
    step(0, 0, 1, 0); chk_all("R3", 8'h00, 8'h00, ~FIXED);
    step(0, 0, 0, 1); chk_all("R11", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_retain();
    step(1, 0, 0, 0);
    pin_out = 8'hA5;
    step(0, 0, 1, 0);
    chk_all("R4", 8'hA5 & ~FIXED, 8'h5A & ~FIXED, ~FIXED);
    chk("R7", "fixed pins", (pull_up | pull_dn | drv_off) & FIXED, 8'h00);
    pin_out = 8'h3C; @(negedge clk);
    chk_all("R4", 8'hA5 & ~FIXED, 8'h5A & ~FIXED, ~FIXED);
    step(0, 0, 0, 1);
    chk_all("R5", 8'hA5 & ~FIXED, 8'h5A & ~FIXED, ~FIXED);
    step(0, 1, 0, 0);
    chk("R6", "ret_en", {7'd0, ret_en}, 8'h00);
    chk_all("R6", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_mask();
    step(1, 0, 0, 0);
    excl_mask = 8'h0F; pin_out = 8'hFF;
    step(0, 0, 1, 0);
    chk_all("R8", 8'h70, 8'h00, 8'h70);
    excl_mask = 8'h00; @(negedge clk);
    chk_all("R8", 8'h7E, 8'h00, 8'h7E);
    step(0, 0, 0, 1);
    step(0, 1, 0, 0);
    chk_all("R6", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_reenter();
    step(1, 0, 0, 0);
    pin_out = 8'h0F; step(0, 0, 1, 0);
    chk_all("R4", 8'h0E, 8'h70, 8'h7E);
    step(0, 0, 0, 1);
    pin_out = 8'hF0; step(0, 0, 1, 0);
    chk_all("R9", 8'h70, 8'h0E, 8'h7E);
    step(0, 0, 0, 1);
    step(0, 1, 0, 0);
    chk_all("R6", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_clr_at_entry();
    step(1, 0, 0, 0);
    pin_out = 8'hFF;
    step(0, 1, 1, 0);
    chk("R10", "ret_en", {7'd0, ret_en}, 8'h00);
    chk_all("R10", 8'h00, 8'h00, ~FIXED);
    step(0, 0, 0, 1);
    chk_all("R11", 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_no_retain();
    t_retain();
    t_mask();
    t_reenter();
    t_clr_at_entry();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule